// File: doc/BRIEF.md
# Two-Wire Serial Slave Protocol Engine

This block is the slave end of a two-wire serial bus (I2C-compatible) for a small serial memory. A fast system clock oversamples the clock line and the data line. Each line passes through a two-flop synchronizer and a glitch filter. The engine then finds start and stop conditions and shifts bytes in and out, most significant bit first. It checks the device select byte, acknowledges each accepted byte, and steps through byte writes, page writes, current-address reads, random reads and sequential reads. The data line is never driven high. The engine only raises a pull-low enable, and the pad ties it to the open-drain line.

Around the engine, an address counter and a write controller do the storage work. The engine gives them a load pulse with the 9-bit word address, a pulse for each data byte received, and a commit pulse when a write is closed by a stop. When it sends, the engine latches the byte on the read-data input and pulses a request in the same cycle, so the counter can move to the next location. The memory array and the address arithmetic sit outside this block.

Top module: `tw_slave_engine`

## Requirements
- R1: A falling data line while the clock line is high is a start, and a rising data line while the clock line is high is a stop. After a stop the engine ignores clock pulses and acknowledges nothing until the next start.
- R2: Each line is synchronized and then filtered. A level is accepted only after GLITCH_CYC consecutive system-clock samples agree, so shorter pulses on either line have no effect on the transfer.
- R3: The first byte after a start is the device select byte, received MSB first. Bits 7:4 must be 1010, bits 3:2 must equal strap_i[1:0], bit 1 is bit 8 of the word address, and bit 0 selects read (1) or write (0). An accepted byte is acknowledged by pulling the data line low for the ninth clock.
- R4: If the device select byte does not match, the engine does not acknowledge it and stays released, without events, until the next start.
- R5: In a write, the second byte is the low word address. Its acknowledge comes with a one-cycle addr_load_o pulse, and addr_word_o = {page bit, byte}.
- R6: Every later byte of a write, with no limit on count, is acknowledged and given as a one-cycle wdata_valid_o pulse with the byte on wdata_o.
- R7: A stop that ends a write in which at least one data byte arrived gives one wr_commit_o pulse. A write that carried only an address (the dummy write of a random read) gives none.
- R8: After a read select byte is acknowledged, the engine latches rdata_i, pulses rd_req_o in that cycle, and sends the byte MSB first. Each bit changes only after a falling clock edge.
- R9: After each byte it sends, the engine releases the line and samples the master's bit on the ninth clock. Low (acknowledge) means it fetches and sends the next byte. High means it stays released until a start or stop.
- R10: A start at any point drops the transfer in progress and restarts device select reception, so a repeated start gives a random read.
- R11: The recovery sequence (a start, nine clocks with the data line high, another start, then a stop) leaves the engine released and idle, and the next transfer works.
- R12: sda_pull_o is 0 during reset, in idle, during the master's acknowledge slot, and for every 1 bit sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Pin-strapped device select bits, compared with select byte bits 3:2 |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 leaves it released |
| addr_load_o | output | 1 | One-cycle pulse: addr_word_o holds a new word address |
| addr_word_o | output | 9 | Word address {page bit, low address byte} |
| wdata_valid_o | output | 1 | One-cycle pulse: wdata_o holds a received data byte |
| wdata_o | output | 8 | Received write data byte |
| rd_req_o | output | 1 | One-cycle pulse: rdata_i was latched for sending |
| rdata_i | input | 8 | Byte at the current read address |
| wr_commit_o | output | 1 | One-cycle pulse: a write with data was closed by a stop |

## Verification
A change at a pad reaches the filtered level GLITCH_CYC+2 system clocks later, and the protocol register adds one more. So the pull-low enable and every event pulse change 13 clocks after the bus edge that causes them. Each bus phase in the bench lasts 20 clocks, so the bench reads the data line at the end of a phase, when every response is already due. Event pulses are compared with an ordered list of expected events on every clock, and any stray pulse fails at once. Glitches last 5 clocks, below the 10-clock filter window, so a result that shows up early or late under a glitch is visible.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire slave engine.
// Assumes: one device select byte layout, 4-bit class code + 3 select/page bits + R/W.
package tw_pkg;

    // Protocol phases of the slave engine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK
    } tw_state_e;

    // Fixed class code carried in the top nibble of the device select byte
    localparam logic [3:0] DEV_CLASS = 4'b1010;

endpackage

// File: rtl/tw_pin_filter.sv
// Synchronizer and glitch filter for one bus line.
// What it does: two flops bring the pad into the clock domain, then a run counter
// accepts a new level only after GLITCH_CYC consecutive agreeing samples.
// Assumes: the idle level of both bus lines is high (pulled up).
module tw_pin_filter #(
    parameter int GLITCH_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYC - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_q;

    // Two-flop synchronizer for the raw pad value
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_i};
    end

    // Count consecutive samples that differ from the accepted level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_o <= 1'b1;
        end else if (sync_q[1] == level_o) begin
            run_q <= '0;
        end else if (run_q == CNT_LAST) begin
            level_o <= sync_q[1];
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2: an accepted change must have been present for at least the last two samples
    a_r2_level_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (GLITCH_CYC >= 3) && !$stable(level_o) |-> ($past(sync_q[1], 2) == level_o));

endmodule

// File: rtl/tw_bus_events.sv
// Edge and condition detector for the filtered bus lines.
// What it does: keeps the previous filtered levels and flags clock rise/fall,
// start (data falls, clock high) and stop (data rises, clock high) for one cycle.
// Assumes: inputs are already synchronized and glitch-filtered.
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl_i,
    input  logic sda_lvl_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Remember last filtered levels to find transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl_i;
            sda_q <= sda_lvl_i;
        end
    end

    assign rise_o  =  scl_lvl_i & ~scl_q;
    assign fall_o  = ~scl_lvl_i &  scl_q;
    assign start_o =  scl_lvl_i &  scl_q &  sda_q & ~sda_lvl_i;
    assign stop_o  =  scl_lvl_i &  scl_q & ~sda_q &  sda_lvl_i;

endmodule

// File: rtl/tw_slave_fsm.sv
// Protocol sequencer of the two-wire slave.
// What it does: shifts bytes in on clock rise, drives acknowledge and read bits
// after clock fall, checks the device select byte, and raises one-cycle events
// for the address counter and write controller.
// Assumes: event inputs are one-cycle pulses from the condition detector;
// ADDR_W is 9 or 10 (one or two page bits inside the select byte).
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter int ADDR_W  = 9,
    localparam int PAGE_W  = ADDR_W - 8,
    localparam int STRAP_W = 3 - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [7:0]        rdata_i,
    output logic              sda_pull_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_word_o,
    output logic              wdata_valid_o,
    output logic [7:0]        wdata_o,
    output logic              rd_req_o,
    output logic              wr_commit_o
);

    tw_state_e         state_q;
    logic [7:0]        sh_q;
    logic [7:0]        tx_q;
    logic [2:0]        bitc_q;
    logic              full_q;
    logic              rd_q;
    logic              mack_q;
    logic              wrote_q;
    logic [PAGE_W-1:0] page_q;
    logic              dev_hit;

    // Select byte matches class code and strapped pins
    assign dev_hit = (sh_q[7:4] == DEV_CLASS) && (sh_q[3 -: STRAP_W] == strap_i);

    // Main protocol sequencer: state, shift registers, line drive and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            sh_q          <= '0;
            tx_q          <= '0;
            bitc_q        <= '0;
            full_q        <= 1'b0;
            rd_q          <= 1'b0;
            mack_q        <= 1'b0;
            wrote_q       <= 1'b0;
            page_q        <= '0;
            sda_pull_o    <= 1'b0;
            addr_load_o   <= 1'b0;
            addr_word_o   <= '0;
            wdata_valid_o <= 1'b0;
            wdata_o       <= '0;
            rd_req_o      <= 1'b0;
            wr_commit_o   <= 1'b0;
        end else begin
            addr_load_o   <= 1'b0;
            wdata_valid_o <= 1'b0;
            rd_req_o      <= 1'b0;
            wr_commit_o   <= 1'b0;
            if (start_i) begin
                state_q    <= ST_DEV;
                bitc_q     <= '0;
                full_q     <= 1'b0;
                wrote_q    <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (stop_i) begin
                wr_commit_o <= wrote_q;
                wrote_q     <= 1'b0;
                state_q     <= ST_IDLE;
                sda_pull_o  <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (rise_i) begin
                            sh_q   <= {sh_q[6:0], sda_lvl_i};
                            bitc_q <= bitc_q + 1'b1;
                            if (bitc_q == 3'd7) full_q <= 1'b1;
                        end else if (fall_i && full_q) begin
                            full_q <= 1'b0;
                            bitc_q <= '0;
                            if (state_q == ST_DEV) begin
                                if (dev_hit) begin
                                    state_q    <= ST_DEV_ACK;
                                    sda_pull_o <= 1'b1;
                                    page_q     <= sh_q[1 +: PAGE_W];
                                    rd_q       <= sh_q[0];
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (state_q == ST_WADDR) begin
                                state_q     <= ST_WADDR_ACK;
                                sda_pull_o  <= 1'b1;
                                addr_load_o <= 1'b1;
                                addr_word_o <= {page_q, sh_q};
                            end else begin
                                state_q       <= ST_WDATA_ACK;
                                sda_pull_o    <= 1'b1;
                                wdata_valid_o <= 1'b1;
                                wdata_o       <= sh_q;
                                wrote_q       <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (fall_i) begin
                            bitc_q <= '0;
                            if (rd_q) begin
                                tx_q       <= rdata_i;
                                rd_req_o   <= 1'b1;
                                sda_pull_o <= ~rdata_i[7];
                                state_q    <= ST_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (fall_i) begin
                            sda_pull_o <= 1'b0;
                            state_q    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (fall_i) begin
                            if (bitc_q == 3'd7) begin
                                sda_pull_o <= 1'b0;
                                state_q    <= ST_RD_ACK;
                            end else begin
                                bitc_q     <= bitc_q + 1'b1;
                                tx_q       <= {tx_q[6:0], 1'b0};
                                sda_pull_o <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (rise_i) begin
                            mack_q <= ~sda_lvl_i;
                        end else if (fall_i) begin
                            bitc_q <= '0;
                            if (mack_q) begin
                                tx_q       <= rdata_i;
                                rd_req_o   <= 1'b1;
                                sda_pull_o <= ~rdata_i[7];
                                state_q    <= ST_RDATA;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: line released whenever the engine is idle
    a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o);

    // R12: the drive only moves while the clock line is low
    a_r12_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_lvl_i);

    // R5: a new word address is acknowledged in the same cycle it is handed over
    a_r5_addr_acked: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load_o |-> (sda_pull_o && $past(fall_i)));

    // R6: each data byte handed over is being acknowledged
    a_r6_data_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_valid_o |-> (sda_pull_o && $past(fall_i)));

    // R7: commit pulses only as the answer to a stop
    a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_i));

    // R8: a read fetch follows a clock fall and lasts one cycle
    a_r8_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> ($past(fall_i) && (state_q == ST_RDATA)) ##1 !rd_req_o);

    // R9: the master's acknowledge slot is never driven
    a_r9_master_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK) |-> !sda_pull_o);

endmodule

// File: rtl/tw_slave_engine.sv
// Top of the two-wire slave protocol engine.
// What it does: filters both bus lines, detects bus conditions and runs the
// protocol sequencer; the data line is only ever pulled low via sda_pull_o.
// Assumes: clk is at least ~20x the bus clock and GLITCH_CYC clocks span the
// noise pulse width to suppress.
module tw_slave_engine #(
    parameter int  GLITCH_CYC = 10,
    parameter int  ADDR_W     = 9,
    localparam int STRAP_W    = 11 - ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic               addr_load_o,
    output logic [ADDR_W-1:0]  addr_word_o,
    output logic               wdata_valid_o,
    output logic [7:0]         wdata_o,
    output logic               rd_req_o,
    input  logic [7:0]         rdata_i,
    output logic               wr_commit_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] pad_raw;
    logic [LINES-1:0] pad_lvl;
    logic             ev_rise;
    logic             ev_fall;
    logic             ev_start;
    logic             ev_stop;

    assign pad_raw = {scl_i, sda_i};

    // One synchronizer and filter per bus line
    for (genvar g = 0; g < LINES; g++) begin : g_line
        tw_pin_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pad_raw[g]),
            .level_o (pad_lvl[g])
        );
    end

    tw_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (pad_lvl[1]),
        .sda_lvl_i (pad_lvl[0]),
        .rise_o    (ev_rise),
        .fall_o    (ev_fall),
        .start_o   (ev_start),
        .stop_o    (ev_stop)
    );

    tw_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (ev_start),
        .stop_i        (ev_stop),
        .rise_i        (ev_rise),
        .fall_i        (ev_fall),
        .scl_lvl_i     (pad_lvl[1]),
        .sda_lvl_i     (pad_lvl[0]),
        .strap_i       (strap_i),
        .rdata_i       (rdata_i),
        .sda_pull_o    (sda_pull_o),
        .addr_load_o   (addr_load_o),
        .addr_word_o   (addr_word_o),
        .wdata_valid_o (wdata_valid_o),
        .wdata_o       (wdata_o),
        .rd_req_o      (rd_req_o),
        .wr_commit_o   (wr_commit_o)
    );

endmodule

// File: tb/tw_slave_engine_tb_top.sv
// Bench: behavioural bus master, a stand-in address counter, and an ordered
// list of expected events compared on every clock.
module tw_slave_engine_tb_top;

    localparam int HALF = 20;
    localparam int GL   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_pull_o, addr_load_o, wdata_valid_o, rd_req_o, wr_commit_o;
    logic [8:0] addr_word_o;
    logic [7:0] wdata_o;
    logic [7:0] rdata_i;
    logic       scl_i, sda_i;

    int  tests = 0;
    int  fails = 0;
    int  ptr = 0;
    int  quiet_viol = 0;
    bit  quiet = 1'b0;
    bit  done = 1'b0;
    int  exp_q[$];

    always #2.5 clk = ~clk;

    assign scl_i = scl_m;
    assign sda_i = sda_m & ~sda_pull_o;

    function automatic logic [7:0] rd_stub(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    assign rdata_i = rd_stub(ptr);

    tw_slave_engine dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap),
        .sda_pull_o(sda_pull_o), .addr_load_o(addr_load_o), .addr_word_o(addr_word_o),
        .wdata_valid_o(wdata_valid_o), .wdata_o(wdata_o), .rd_req_o(rd_req_o),
        .rdata_i(rdata_i), .wr_commit_o(wr_commit_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            1: return "R5 address load";
            2: return "R6 write data";
            3: return "R8 read fetch";
            default: return "R7 write commit";
        endcase
    endfunction

    task automatic ev_check(input int kind, input int val);
        int e;
        if (exp_q.size() == 0) begin
            chk(1'b0, kind_tag(kind), (kind << 16) | val, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e == ((kind << 16) | val), kind_tag(kind), (kind << 16) | val, e);
        end
    endtask

    // Event monitor and stand-in address counter, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_load_o) begin
                ev_check(1, int'(addr_word_o));
                ptr = int'(addr_word_o);
            end
            if (wdata_valid_o) ev_check(2, int'(wdata_o));
            if (rd_req_o) begin
                ev_check(3, 0);
                ptr = (ptr + 1) % 512;
            end
            if (wr_commit_o) ev_check(4, 0);
            if (quiet && sda_pull_o) quiet_viol++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] st, input logic pg, input logic rw);
        return {4'b1010, st, pg, rw};
    endfunction

    // One bus clock; g=1 glitches the clock line, g=2 glitches the data line low
    task automatic clock_bit(input bit b, input int g, output bit s);
        sda_m = b;
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(5);
        if (g == 1) begin scl_m = 1'b0; wait_clk(GL); scl_m = 1'b1; end
        else if (g == 2) begin sda_m = 1'b0; wait_clk(GL); sda_m = b; end
        else wait_clk(GL);
        wait_clk(HALF - 5 - GL);
        s = sda_i;
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF);
        end
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack,
                             input int gbit = -1, input int gkind = 0);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], (i == gbit) ? gkind : 0, s);
        clock_bit(1'b1, 0, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, 0, s);
            b = {b[6:0], s};
        end
        clock_bit(!mack, 0, s);
    endtask

    initial begin
        bit         ack;
        logic [7:0] rb;

        wait_clk(10);
        chk(sda_pull_o == 1'b0, "R12 released in reset", sda_pull_o, 0);
        rst_n = 1'b1;
        wait_clk(40);
        chk({sda_pull_o, addr_load_o, wdata_valid_o, rd_req_o, wr_commit_o} == 5'b0,
            "R12 reset state", {sda_pull_o, addr_load_o, wdata_valid_o, rd_req_o, wr_commit_o}, 0);

        // R3 R5 R6 R7: byte write with page bit set
        bus_start();
        send_byte(dev(2'b10, 1'b1, 1'b0), ack);
        chk(ack, "R3 select byte acknowledged", ack, 1);
        exp_q.push_back((1 << 16) | 9'h13C);
        send_byte(8'h3C, ack);
        chk(ack, "R5 word address acknowledged", ack, 1);
        exp_q.push_back((2 << 16) | 8'hA5);
        send_byte(8'hA5, ack);
        chk(ack, "R6 data byte acknowledged", ack, 1);
        exp_q.push_back(4 << 16);
        bus_stop();
        wait_clk(40);
        chk(exp_q.size() == 0, "R7 byte write events all seen", exp_q.size(), 0);

        // R6 R7: page write of four bytes
        bus_start();
        send_byte(dev(2'b10, 1'b0, 1'b0), ack);
        exp_q.push_back((1 << 16) | 9'h010);
        send_byte(8'h10, ack);
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back((2 << 16) | (8'h61 + k));
            send_byte(8'(8'h61 + k), ack);
            chk(ack, "R6 page write byte acknowledged", ack, 1);
        end
        exp_q.push_back(4 << 16);
        bus_stop();
        wait_clk(40);
        chk(exp_q.size() == 0, "R7 page write events all seen", exp_q.size(), 0);

        // R4: strap mismatch, nothing acknowledged, no events
        quiet = 1'b1; quiet_viol = 0;
        bus_start();
        send_byte(dev(2'b01, 1'b0, 1'b0), ack);
        chk(!ack, "R4 strap mismatch not acknowledged", ack, 0);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        chk(!ack, "R4 later bytes ignored", ack, 0);
        bus_stop();
        wait_clk(40);
        chk(quiet_viol == 0, "R4 line stays released", quiet_viol, 0);

        // R3: wrong class code
        bus_start();
        send_byte(8'b1011_1000, ack);
        chk(!ack, "R3 wrong class code not acknowledged", ack, 0);
        bus_stop();
        wait_clk(40);
        chk(quiet_viol == 0, "R3 released on wrong class", quiet_viol, 0);
        quiet = 1'b0;

        // R10 R8 R9: random read across the top of memory, sequential
        bus_start();
        send_byte(dev(2'b10, 1'b1, 1'b0), ack);
        exp_q.push_back((1 << 16) | 9'h1FE);
        send_byte(8'hFE, ack);
        bus_start();
        exp_q.push_back(3 << 16);
        send_byte(dev(2'b10, 1'b1, 1'b1), ack);
        chk(ack, "R10 read select after repeated start acknowledged", ack, 1);
        exp_q.push_back(3 << 16);
        recv_byte(1'b1, rb);
        chk(rb == rd_stub(9'h1FE), "R8 first read byte", rb, rd_stub(9'h1FE));
        exp_q.push_back(3 << 16);
        recv_byte(1'b1, rb);
        chk(rb == rd_stub(9'h1FF), "R9 sequential byte after ack", rb, rd_stub(9'h1FF));
        recv_byte(1'b0, rb);
        chk(rb == rd_stub(0), "R9 third byte after counter wrap", rb, rd_stub(0));
        quiet = 1'b1; quiet_viol = 0;
        wait_clk(HALF);
        bus_stop();
        wait_clk(40);
        chk(quiet_viol == 0, "R9 released after master no-ack", quiet_viol, 0);
        chk(exp_q.size() == 0, "R7 dummy write gives no commit", exp_q.size(), 0);
        quiet = 1'b0;

        // R8: current-address read continues where the counter stands
        bus_start();
        exp_q.push_back(3 << 16);
        send_byte(dev(2'b10, 1'b0, 1'b1), ack);
        recv_byte(1'b0, rb);
        chk(rb == rd_stub(1), "R8 current address read", rb, rd_stub(1));
        bus_stop();
        wait_clk(40);

        // R10: start in the middle of a data byte aborts the write
        bus_start();
        send_byte(dev(2'b10, 1'b0, 1'b0), ack);
        exp_q.push_back((1 << 16) | 9'h020);
        send_byte(8'h20, ack);
        for (int i = 0; i < 4; i++) begin
            bit s;
            clock_bit(1'b0, 0, s);
        end
        bus_start();
        exp_q.push_back(3 << 16);
        send_byte(dev(2'b10, 1'b0, 1'b1), ack);
        chk(ack, "R10 select after abort acknowledged", ack, 1);
        recv_byte(1'b0, rb);
        chk(rb == rd_stub(9'h020), "R10 read after aborted write", rb, rd_stub(9'h020));
        bus_stop();
        wait_clk(40);
        chk(exp_q.size() == 0, "R10 aborted write gives no data or commit", exp_q.size(), 0);

        // R2: short glitches on clock and data are ignored
        bus_start();
        send_byte(dev(2'b10, 1'b0, 1'b0), ack, 3, 1);
        chk(ack, "R2 clock glitch ignored in select byte", ack, 1);
        exp_q.push_back((1 << 16) | 9'h0C5);
        send_byte(8'hC5, ack, 6, 2);
        chk(ack, "R2 data glitch ignored in address byte", ack, 1);
        exp_q.push_back((2 << 16) | 8'h5E);
        send_byte(8'h5E, ack);
        exp_q.push_back(4 << 16);
        bus_stop();
        wait_clk(40);
        chk(exp_q.size() == 0, "R2 glitched write events all seen", exp_q.size(), 0);

        // R11: recovery sequence after an interrupted transfer
        bus_start();
        for (int i = 0; i < 3; i++) begin
            bit s;
            clock_bit(1'b1, 0, s);
        end
        quiet = 1'b1; quiet_viol = 0;
        bus_start();
        for (int i = 0; i < 9; i++) begin
            bit s;
            clock_bit(1'b1, 0, s);
        end
        bus_start();
        bus_stop();
        wait_clk(40);
        chk(quiet_viol == 0, "R11 released through recovery", quiet_viol, 0);
        quiet = 1'b0;
        bus_start();
        send_byte(dev(2'b10, 1'b0, 1'b0), ack);
        chk(ack, "R11 next transfer acknowledged", ack, 1);
        exp_q.push_back((1 << 16) | 9'h077);
        send_byte(8'h77, ack);
        exp_q.push_back((2 << 16) | 8'h01);
        send_byte(8'h01, ack);
        exp_q.push_back(4 << 16);
        bus_stop();
        wait_clk(40);
        chk(exp_q.size() == 0, "R11 write after recovery complete", exp_q.size(), 0);

        // R1: after a stop, clocks without a start are ignored
        quiet = 1'b1; quiet_viol = 0;
        scl_m = 1'b0;
        wait_clk(HALF);
        send_byte(dev(2'b10, 1'b0, 1'b0), ack);
        chk(!ack, "R1 no acknowledge without start", ack, 0);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(40);
        chk(quiet_viol == 0, "R1 released without start", quiet_viol, 0);
        chk(exp_q.size() == 0, "R1 no events without start", exp_q.size(), 0);
        quiet = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule